// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the serial-side controller of a byte-wide EEPROM that answers on a two-wire bus. It runs on a fast system clock and sees SCL and SDA only through synchronizers. It recognises bus start and stop conditions and receives a select byte, a word-address byte and data bytes. It drives SDA low through an open-drain output enable to acknowledge and to return read data. Received write bytes are loaded into a 16-byte page buffer. The page buffer is written into a synchronous byte RAM after the stop condition. If a new start arrives before that stop, the buffered bytes are dropped.

The array holds 512, 1024 or 2048 bytes (`MEM_BYTES`). The select byte carries three chip-select bits. As the array grows, fewer of these bits are compared with the strap pins. The bits that are not compared become the high bits of the word address, and the lowest of them maps to address bit 8. An address counter keeps its value across transactions. A read that begins with no address phase returns the byte at the counter. Reads may continue byte after byte. A random read is a dummy write that sets the address, then a repeated start and a read-mode select.

Top module: `eeprom_twi_slave`

## Requirements
- R1: After reset, and within a few clocks after any STOP, SDA is released (`sda_oe_o` = 0) and the engine is idle. A START at any time restarts reception of a select byte.
- R2: A select byte is accepted only when bits [7:4] are 1010 and the compared chip-select bits match the straps. For 512 bytes, select bits [3:2] are compared with `strap_i[2:1]` and bit [1] is word-address bit 8. Bit [0] set to 1 means read. On a mismatch there is no acknowledge, and every following byte is ignored until the next START.
- R3: Each byte the slave receives is acknowledged by holding SDA low across the 9th SCL clock. SDA is released after that clock's falling edge.
- R4: A write sets the address to {select high bits, word byte}. A received data byte reaches the array only after a STOP.
- R5: Within a page write, the low 4 address bits advance after each data byte and wrap inside the 16-byte page. The 17th byte replaces the first one.
- R6: The address counter holds the last accessed address plus one, across transactions. A read-mode select with no address phase starts at that counter.
- R7: A read returns another byte each time the master acknowledges. The counter wraps from the top address to 0.
- R8: A write-mode select plus a word-address byte, followed by a repeated START and a read-mode select, returns the byte at that address. Nothing is programmed.
- R9: A START that arrives after data bytes were loaded but before a STOP discards them. The array is left unchanged.
- R10: The slave changes SDA only while SCL is low.
- R11: After the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Chip-select straps, bit 2 first in compare order |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The case hardest to reach from the ports is a write whose bytes sit loaded in the page buffer when a repeated START arrives. The bytes must be dropped rather than committed, and nothing inside can be observed directly. The bench loads a byte over a known value, then issues a START and a STOP without a write stop in between. It then reads the address back through a random read. Column wrap and counter wrap are reached with directed page writes that run past a page end and reads that begin just below the top address. Random page writes and reads, checked against a bench memory model, cover the rest.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RD
  } twi_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int PAGE_COL_W = 4;
  localparam int SEL_BITS   = 3;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d1, sda_d1;

  // bus idles high, so reset to 1 avoids a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d1 <= 1'b1;
      sda_d1 <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d1 <= scl_ff[SYNC_STAGES-1];
      sda_d1 <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d1;
  assign scl_fall_o = ~scl_o & scl_d1;
  assign start_o    = scl_o & scl_d1 & sda_d1 & ~sda_o;
  assign stop_o     = scl_o & scl_d1 & ~sda_d1 & sda_o;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int ROW_W = 5,
  parameter int COL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [COL_W-1:0]       col_i,
  input  logic [7:0]             data_i,
  input  logic                   discard_i,
  input  logic                   commit_i,
  output logic                   wr_en_o,
  output logic [ROW_W+COL_W-1:0] wr_addr_o,
  output logic [7:0]             wr_data_o,
  output logic                   busy_o
);
  localparam int SLOTS = 1 << COL_W;

  logic [7:0]       slot_q [SLOTS];
  logic [SLOTS-1:0] vld_q, vld_d;
  logic [ROW_W-1:0] row_q;
  logic             busy_q, busy_d;
  logic [COL_W-1:0] idx_q, idx_d;
  logic             take;

  assign take = load_i & ~busy_q;

  always_comb begin
    vld_d  = vld_q;
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      vld_d[idx_q] = 1'b0;
      idx_d        = idx_q + 1'b1;
      if (idx_q == COL_W'(SLOTS - 1)) busy_d = 1'b0;
    end else if (commit_i) begin
      busy_d = |vld_q;
      idx_d  = '0;
    end else if (discard_i) begin
      vld_d = '0;
    end else if (load_i) begin
      vld_d[col_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      row_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      busy_q <= busy_d;
      idx_q  <= idx_d;
      if (take) row_q <= row_i;
    end
  end

  // data slots carry no reset; the valid bits qualify them
  always_ff @(posedge clk) begin
    if (take) slot_q[col_i] <= data_i;
  end

  assign wr_en_o   = busy_q & vld_q[idx_q];
  assign wr_addr_o = {row_q, idx_q};
  assign wr_data_o = slot_q[idx_q];
  assign busy_o    = busy_q;
endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
  import twi_eep_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int HI_W  = AW - 8;
  localparam int COL_W = PAGE_COL_W;
  localparam int ROW_W = AW - COL_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_lvl),
    .sda_o      (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  twi_state_e      st_q, st_d;
  logic [3:0]      bit_q, bit_d;
  logic [7:0]      sh_q, sh_d;
  logic [7:0]      tx_q, tx_d;
  logic            oe_q, oe_d;
  logic            rw_q, rw_d;
  logic            mack_q, mack_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [AW-1:0]   addr_q, addr_d;

  logic            pb_load, pb_discard, pb_commit, pb_busy;
  logic            ram_we;
  logic [AW-1:0]   ram_waddr;
  logic [7:0]      ram_wdata, ram_q;
  logic            sel_ok;

  // select compare: bits below HI_W+1 are address, the rest match straps
  always_comb begin
    sel_ok = (sh_q[7:4] == DEV_CODE);
    for (int i = 0; i < SEL_BITS; i++) begin
      if (i >= HI_W && sh_q[i+1] != strap_i[i]) sel_ok = 1'b0;
    end
  end

  always_comb begin
    st_d       = st_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    tx_d       = tx_q;
    oe_d       = oe_q;
    rw_d       = rw_q;
    mack_d     = mack_q;
    hi_d       = hi_q;
    addr_d     = addr_q;
    pb_load    = 1'b0;
    pb_discard = 1'b0;
    pb_commit  = 1'b0;
    if (start_evt) begin
      st_d       = ST_DEV;
      bit_d      = '0;
      oe_d       = 1'b0;
      pb_discard = 1'b1;
    end else if (stop_evt) begin
      st_d      = ST_IDLE;
      bit_d     = '0;
      oe_d      = 1'b0;
      pb_commit = (st_q == ST_WDATA);
    end else if (scl_rise && st_q != ST_IDLE) begin
      if (bit_q < 4'd8) begin
        if (st_q != ST_RD) sh_d = {sh_q[6:0], sda_lvl};
        bit_d = bit_q + 1'b1;
      end else if (bit_q == 4'd8) begin
        bit_d  = 4'd9;
        mack_d = ~sda_lvl;
      end
    end else if (scl_fall) begin
      unique case (st_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (bit_q == 4'd8) begin
            if (st_q == ST_DEV) begin
              if (sel_ok) begin
                oe_d = 1'b1;
                rw_d = sh_q[0];
                hi_d = sh_q[HI_W:1];
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              oe_d = 1'b1;
              if (st_q == ST_WDATA) begin
                pb_load = 1'b1;
                addr_d  = {addr_q[AW-1:COL_W], COL_W'(addr_q[COL_W-1:0] + 1'b1)};
              end
            end
          end else if (bit_q == 4'd9) begin
            oe_d  = 1'b0;
            bit_d = '0;
            if (st_q == ST_DEV) begin
              if (rw_q) begin
                st_d   = ST_RD;
                tx_d   = ram_q;
                oe_d   = ~ram_q[7];
                addr_d = addr_q + 1'b1;
              end else begin
                st_d = ST_ADDR;
              end
            end else if (st_q == ST_ADDR) begin
              addr_d = {hi_q, sh_q};
              st_d   = ST_WDATA;
            end
          end
        end
        ST_RD: begin
          if (bit_q >= 4'd1 && bit_q <= 4'd7) begin
            oe_d = ~tx_q[3'(4'd7 - bit_q)];
          end else if (bit_q == 4'd8) begin
            oe_d = 1'b0;
          end else if (bit_q == 4'd9) begin
            bit_d = '0;
            if (mack_q) begin
              tx_d   = ram_q;
              oe_d   = ~ram_q[7];
              addr_d = addr_q + 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      oe_q   <= oe_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      hi_q   <= hi_d;
      addr_q <= addr_d;
    end
  end

  assign sda_oe_o = oe_q;

  twi_page_buf #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pbuf (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load_i    (pb_load),
    .row_i     (addr_q[AW-1:COL_W]),
    .col_i     (addr_q[COL_W-1:0]),
    .data_i    (sh_q),
    .discard_i (pb_discard),
    .commit_i  (pb_commit),
    .wr_en_o   (ram_we),
    .wr_addr_o (ram_waddr),
    .wr_data_o (ram_wdata),
    .busy_o    (pb_busy)
  );

  twi_byte_ram #(.DEPTH(MEM_BYTES), .AW(AW)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (addr_q),
    .rdata_o (ram_q)
  );
endmodule

// File: rtl/twi_eep_chk.sv
module twi_eep_chk
  import twi_eep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input twi_state_e st,
  input logic [3:0] bitcnt,
  input logic       pb_busy,
  input logic       pb_load
);
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE && !sda_oe));

  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_DEV && bitcnt == 4'd0));

  assert_ack_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && (st == ST_DEV || st == ST_ADDR || st == ST_WDATA)) |-> bitcnt >= 4'd8);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st == ST_IDLE)) |-> !sda_oe);

  assert_no_load_in_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pb_busy |-> !pb_load);
endmodule

bind eeprom_twi_slave twi_eep_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .scl_lvl   (scl_lvl),
  .sda_oe    (sda_oe_o),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .st        (st_q),
  .bitcnt    (bit_q),
  .pb_busy   (pb_busy),
  .pb_load   (pb_load)
);

// File: tb/eeprom_twi_slave_tb_top.sv
`timescale 1ns/1ps
module eeprom_twi_slave_tb_top;
  localparam logic [2:0] STRAP = 3'b010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  eeprom_twi_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .strap_i  (STRAP),
    .sda_oe_o (sda_oe)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int r10_viol = 0;

  logic [7:0] mem_m   [512];
  bit         known_m [512];
  logic [8:0] cnt_m;
  logic [7:0] wbuf    [32];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // R10 monitor: SDA drive may change only while SCL is low
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (sda_oe !== prev_oe && scl_m === 1'b1) r10_viol++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  task automatic mst_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic mst_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    b = sda_bus; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~mack);
  endtask

  function automatic logic [7:0] sel(input logic [8:0] a, input logic rw);
    return {4'b1010, STRAP[2], STRAP[1], a[8], rw};
  endfunction

  function automatic logic [8:0] page_idx(input logic [8:0] a, input int k);
    return {a[8:4], 4'(a[3:0] + k)};
  endfunction

  task automatic wr_txn(input logic [8:0] a, input int n);
    logic ack;
    mst_start();
    write_byte(sel(a, 1'b0), ack); chk("R3 select ack", 16'(ack), 16'd1);
    write_byte(a[7:0], ack);       chk("R3 address ack", 16'(ack), 16'd1);
    for (int k = 0; k < n; k++) begin
      write_byte(wbuf[k], ack);
      chk("R3 data ack", 16'(ack), 16'd1);
    end
    mst_stop();
    tick(40);
    for (int k = 0; k < n; k++) begin
      mem_m[page_idx(a, k)]   = wbuf[k];
      known_m[page_idx(a, k)] = 1'b1;
    end
    cnt_m = page_idx(a, n);
  endtask

  task automatic rd_cur(input int n, input string req);
    logic ack;
    logic [7:0] d;
    mst_start();
    write_byte(sel(9'd0, 1'b1), ack); chk(req, 16'(ack), 16'd1);
    for (int k = 0; k < n; k++) begin
      read_byte(d, k < n - 1);
      if (known_m[cnt_m]) chk(req, 16'(d), 16'(mem_m[cnt_m]));
      cnt_m = cnt_m + 1'b1;
    end
    mst_stop();
    tick(20);
  endtask

  task automatic rd_rand(input logic [8:0] a, input int n, input string req);
    logic ack;
    mst_start();
    write_byte(sel(a, 1'b0), ack); chk(req, 16'(ack), 16'd1);
    write_byte(a[7:0], ack);       chk(req, 16'(ack), 16'd1);
    cnt_m = a;
    rd_cur(n, req);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int seed_v;
    seed_v = $urandom(32'h5eed_1234);
    for (int i = 0; i < 512; i++) known_m[i] = 1'b0;
    cnt_m = '0;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R1: reset state
    chk("R1 reset oe", 16'(sda_oe), 16'd0);
    chk("R1 reset bus", 16'(sda_bus), 16'd1);

    // R4: byte write at an address with bit 8 set, then read back
    wbuf[0] = 8'h3C;
    wr_txn(9'h15A, 1);
    chk("R3 released after ack", 16'(sda_oe), 16'd0);
    rd_rand(9'h15A, 1, "R4 byte write readback");

    // R6 / R8: fill a page, random read, then current-address reads
    for (int k = 0; k < 16; k++) wbuf[k] = 8'(8'h40 + k * 3);
    wr_txn(9'h150, 16);
    rd_rand(9'h15A, 1, "R8 random read");
    rd_rand(9'h15A, 1, "R8 dummy write programs nothing");
    rd_cur(2, "R6 current address read");

    // R5: page write running past the page end
    for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h90 + k);
    wr_txn(9'h1F8, 18);
    rd_cur(1, "R6 counter after page write");
    rd_rand(9'h1F0, 16, "R5 column wrap");

    // R7: sequential read across the top of the array
    for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hC0 + k);
    wr_txn(9'h000, 4);
    rd_rand(9'h1FE, 4, "R7 sequential wrap");

    // R2: wrong strap bits, then an ignored byte
    mst_start();
    write_byte({4'b1010, ~STRAP[2], STRAP[1], 1'b0, 1'b0}, ack);
    chk("R2 strap mismatch nack", 16'(ack), 16'd0);
    write_byte(8'h00, ack);
    chk("R2 ignored until start", 16'(ack), 16'd0);
    mst_stop();
    tick(20);
    // R2: wrong device code
    mst_start();
    write_byte(8'b1011_0100, ack);
    chk("R2 code mismatch nack", 16'(ack), 16'd0);
    mst_stop();
    tick(20);

    // R9: loaded byte dropped by a repeated START
    wbuf[0] = 8'hA5;
    wr_txn(9'h020, 1);
    mst_start();
    write_byte(sel(9'h020, 1'b0), ack); chk("R9 select ack", 16'(ack), 16'd1);
    write_byte(8'h20, ack);             chk("R9 address ack", 16'(ack), 16'd1);
    write_byte(8'h5A, ack);             chk("R9 data ack", 16'(ack), 16'd1);
    mst_start();
    mst_stop();
    tick(40);
    rd_rand(9'h020, 1, "R9 discarded write");

    // R11: after master NACK the slave stays off the bus
    mst_start();
    write_byte(sel(9'h020, 1'b0), ack);
    write_byte(8'h20, ack);
    mst_start();
    write_byte(sel(9'h0, 1'b1), ack);
    read_byte(d, 1'b0);
    chk("R11 last byte", 16'(d), 16'h00A5);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      d[i] = b;
    end
    chk("R11 bus idle after nack", 16'(d), 16'h00FF);
    chk("R11 oe released", 16'(sda_oe), 16'd0);
    mst_stop();
    tick(20);
    cnt_m = 9'h021;

    // random page writes and reads against the model
    for (int it = 0; it < 10; it++) begin
      logic [8:0] a;
      int n;
      a = 9'($urandom);
      n = 1 + int'($urandom % 20);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(a, n);
      rd_rand(9'($urandom), 1 + int'($urandom % 6), "R4 random");
      rd_rand(a, n > 16 ? 16 : n, "R5 random page");
    end

    chk("R10 sda changes only with scl low", 16'(r10_viol), 16'd0);
    chk("R1 idle at end", 16'(sda_oe), 16'd0);
    finish_run();
  end
endmodule